// File: doc/BRIEF.md
# Dual Reloadable Down-Counter Timer with PWM and Cascade

This block holds two 8-bit down counters. Each one counts enabled ticks. A tick comes from one of sixteen single-cycle clock-enable inputs, and the first counter can count rising edges of an external event line instead. When a counter is at zero and receives an enabled tick, it reloads from its reload register and raises an underflow pulse. The second counter's underflow pulse also leaves the block as a clock source for other peripherals.

Each counter has a compare register. In PWM mode, a tick consumed while the count equals the compare value raises a match pulse and drives the waveform active. The next underflow drives it inactive again. Outside PWM mode the waveform toggles at each underflow. A polarity bit and an output-enable bit shape each pin.

The two counters can be joined into one 16-bit down counter. In that mode the first counter is the low byte and the second is the high byte. The pair is configured through a simple register write port.

Top module: `dual_down_timer`

## Requirements
- R1: After reset, both counts, all reload, compare and control registers, both waveforms and every pulse output are 0, and both pins are low.
- R2: An enabled tick that finds a count of 0 loads the reload value into that counter. In the next cycle the matching bit of irqUf is high for exactly one cycle. For counter 1, ufOut carries the same pulse.
- R3: A counter's count enable is its run bit AND tickIn[its clkSel field]. An enabled tick at a nonzero count lowers the count by one. Without an enabled tick the count holds, and clearing the run bit stops counting.
- R4: Writes with wrEn high use these addresses: 0 and 1 reload of counter 0/1, 2 and 3 compare of counter 0/1, 4 and 5 control of counter 0/1, 6 mode, 7 reset strobe. Control bits are clkSel [3:0], run [4], PWM [5], polarity [6] and output enable [7]. Mode bits are cascade [0] and event mode [1]. A written control or mode value governs counting from the following cycle.
- R5: Writing a reload register leaves the running count untouched. The new value is used only at the next underflow or reset strobe.
- R6: A write to address 7 with data bit n set loads counter n from its reload register and clears its waveform. In cascade mode, either bit loads both counters and clears waveform 1.
- R7: In PWM mode, an enabled tick consumed at count == compare pulses irqCmp for one cycle and sets the waveform. An underflow clears the waveform, and when both happen on one tick the underflow wins.
- R8: Outside PWM mode, each underflow inverts the waveform and irqCmp stays low.
- R9: pinOut[n] is (waveform XOR polarity) when output enable is 1, and 0 when it is 0.
- R10: In event mode, counter 0 counts rising edges of evtIn in place of its clock tick, still gated by its run bit. Each edge is counted 3 clock edges after evtIn rises.
- R11: In cascade mode, the pair is one 16-bit count {cntHi,cntLo}. It is clocked by counter 0's enable and lowered by one per enabled tick, with the low byte wrapping from 0 to 255. At 0 it reloads both bytes.
- R12: In cascade mode, the 16-bit underflow and 16-bit compare match are reported on index 1 using counter 1's PWM, polarity and enable bits. Index 0 pulses stay low and pinOut[0] is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | W | Write data |
| tickIn | input | 16 | Clock-enable ticks selectable per counter |
| evtIn | input | 1 | External event line (asynchronous) |
| cntLo | output | W | Live count of counter 0 |
| cntHi | output | W | Live count of counter 1 |
| irqUf | output | 2 | Underflow interrupt pulses |
| irqCmp | output | 2 | Compare-match interrupt pulses |
| ufOut | output | 1 | Counter 1 (or 16-bit) underflow pulse for peripherals |
| pinOut | output | 2 | Timer output pins |

## Verification
A tick sampled at a clock edge shows up in the counts, waveforms, pins and interrupt pulses right after that same edge. A register write counts from the following edge. An evtIn rise is counted at the third edge after it. The bench keeps a behavioural model that steps on the same edge as the design, using the inputs the design saw at that edge. It compares every output on the falling edge, away from the sampling edge, so each of these latencies is checked in the cycle where it applies.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W   = 4;
  localparam int NUM_TMR = 2;

  localparam logic [2:0] A_RLD0 = 3'd0;
  localparam logic [2:0] A_CMP0 = 3'd2;
  localparam logic [2:0] A_CTL0 = 3'd4;
  localparam logic [2:0] A_MODE = 3'd6;
  localparam logic [2:0] A_RST  = 3'd7;

  typedef struct packed {
    logic load;
    logic dec;
  } cntStrb_t;

  typedef struct packed {
    logic             outEn;
    logic             pol;
    logic             pwm;
    logic             run;
    logic [SEL_W-1:0] clkSel;
  } tmrCtrl_t;
endpackage

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [2:0]                    wrAddr,
  input  logic [W-1:0]                  wrData,
  input  cntStrb_t [NUM_TMR-1:0]        strb,
  output logic [NUM_TMR-1:0][W-1:0]     cnt,
  output logic [NUM_TMR-1:0][W-1:0]     rld,
  output logic [NUM_TMR-1:0]            zero,
  output logic [NUM_TMR-1:0]            eq
);
  logic [NUM_TMR-1:0][W-1:0] cmp;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam logic [2:0] ARLD = A_RLD0 + 3'(i);
    localparam logic [2:0] ACMP = A_CMP0 + 3'(i);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rld[i] <= '0;
        cmp[i] <= '0;
        cnt[i] <= '0;
      end else begin
        if (wrEn && wrAddr == ARLD) rld[i] <= wrData;
        if (wrEn && wrAddr == ACMP) cmp[i] <= wrData;
        if (strb[i].load)      cnt[i] <= rld[i];
        else if (strb[i].dec)  cnt[i] <= cnt[i] - 1'b1;
      end
    end

    assign zero[i] = (cnt[i] == '0);
    assign eq[i]   = (cnt[i] == cmp[i]);

    // R3: with neither strobe the count must not move
    a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!strb[i].load && !strb[i].dec) |=> $stable(cnt[i]));
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [2:0]               wrAddr,
  input  logic [W-1:0]             wrData,
  input  logic [(1<<SEL_W)-1:0]    tickIn,
  input  logic                     evtIn,
  input  logic [NUM_TMR-1:0]       zero,
  input  logic [NUM_TMR-1:0]       eq,
  output cntStrb_t [NUM_TMR-1:0]   strb,
  output logic [NUM_TMR-1:0]       irqUf,
  output logic [NUM_TMR-1:0]       irqCmp,
  output logic [NUM_TMR-1:0]       pinOut,
  output logic                     cascMode
);
  tmrCtrl_t [NUM_TMR-1:0] ctl;
  logic evtMode, evtMeta, evtSync, evtPrev, evtRise;
  logic [NUM_TMR-1:0] rstStb, tickSel, en, ufEv, mEv, wRst, wave;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl      <= '0;
      cascMode <= 1'b0;
      evtMode  <= 1'b0;
      evtMeta  <= 1'b0;
      evtSync  <= 1'b0;
      evtPrev  <= 1'b0;
    end else begin
      if (wrEn && wrAddr == A_CTL0)        ctl[0] <= tmrCtrl_t'(wrData[7:0]);
      if (wrEn && wrAddr == A_CTL0 + 3'd1) ctl[1] <= tmrCtrl_t'(wrData[7:0]);
      if (wrEn && wrAddr == A_MODE) begin
        cascMode <= wrData[0];
        evtMode  <= wrData[1];
      end
      evtMeta <= evtIn;
      evtSync <= evtMeta;
      evtPrev <= evtSync;
    end
  end

  assign evtRise = evtSync & ~evtPrev;
  assign rstStb  = (wrEn && wrAddr == A_RST) ? wrData[NUM_TMR-1:0] : '0;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_sel
    assign tickSel[i] = tickIn[ctl[i].clkSel];
  end
  assign en[0] = ctl[0].run & (evtMode ? evtRise : tickSel[0]);
  assign en[1] = ctl[1].run & tickSel[1];

  always_comb begin
    strb = '0;
    ufEv = '0;
    mEv  = '0;
    wRst = '0;
    if (cascMode) begin
      ufEv[1]      = en[0] & zero[0] & zero[1];
      mEv[1]       = en[0] & eq[0] & eq[1] & ctl[1].pwm;
      strb[0].load = (|rstStb) | ufEv[1];
      strb[1].load = (|rstStb) | ufEv[1];
      strb[0].dec  = en[0] & ~ufEv[1];
      strb[1].dec  = en[0] & zero[0] & ~zero[1];
      wRst         = {(|rstStb), rstStb[0]};
    end else begin
      for (int i = 0; i < NUM_TMR; i++) begin
        ufEv[i]      = en[i] & zero[i];
        mEv[i]       = en[i] & eq[i] & ctl[i].pwm;
        strb[i].load = rstStb[i] | ufEv[i];
        strb[i].dec  = en[i] & ~zero[i];
      end
      wRst = rstStb;
    end
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wave[i]   <= 1'b0;
        irqUf[i]  <= 1'b0;
        irqCmp[i] <= 1'b0;
      end else begin
        irqUf[i]  <= ufEv[i];
        irqCmp[i] <= mEv[i];
        if (wRst[i])      wave[i] <= 1'b0;
        else if (ufEv[i]) wave[i] <= ctl[i].pwm ? 1'b0 : ~wave[i];
        else if (mEv[i])  wave[i] <= 1'b1;
      end
    end

    if (i == 0) begin : g_lo
      assign pinOut[i] = ctl[i].outEn & (wave[i] ^ ctl[i].pol) & ~cascMode;
    end else begin : g_hi
      assign pinOut[i] = ctl[i].outEn & (wave[i] ^ ctl[i].pol);
    end

    a_r7_match_sets_wave: assert property (@(posedge clk) disable iff (!rstN)
      (irqCmp[i] && !irqUf[i] && !$past(wRst[i])) |-> wave[i]);
    a_r7_uf_clears_wave: assert property (@(posedge clk) disable iff (!rstN)
      (irqUf[i] && $past(ctl[i].pwm)) |-> !wave[i]);
    a_r8_cmp_needs_pwm: assert property (@(posedge clk) disable iff (!rstN)
      irqCmp[i] |-> $past(ctl[i].pwm));
  end

  a_r12_low_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $past(cascMode) |-> (!irqUf[0] && !irqCmp[0]));
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [2:0]             wrAddr,
  input  logic [W-1:0]           wrData,
  input  logic [(1<<SEL_W)-1:0]  tickIn,
  input  logic                   evtIn,
  output logic [W-1:0]           cntLo,
  output logic [W-1:0]           cntHi,
  output logic [1:0]             irqUf,
  output logic [1:0]             irqCmp,
  output logic                   ufOut,
  output logic [1:0]             pinOut
);
  cntStrb_t [NUM_TMR-1:0]    strb;
  logic [NUM_TMR-1:0][W-1:0] cnt, rld;
  logic [NUM_TMR-1:0]        zero, eq;
  logic                      cascMode;

  tmr_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tickIn(tickIn), .evtIn(evtIn), .zero(zero), .eq(eq), .strb(strb),
    .irqUf(irqUf), .irqCmp(irqCmp), .pinOut(pinOut), .cascMode(cascMode)
  );

  tmr_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strb(strb), .cnt(cnt), .rld(rld), .zero(zero), .eq(eq)
  );

  assign cntLo = cnt[0];
  assign cntHi = cnt[1];
  assign ufOut = irqUf[1];

  a_r2_reload_lo: assert property (@(posedge clk) disable iff (!rstN)
    irqUf[0] |-> cntLo == $past(rld[0]));
  a_r2_reload_hi: assert property (@(posedge clk) disable iff (!rstN)
    irqUf[1] |-> cntHi == $past(rld[1]));
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (cntLo != $past(cntLo) && !irqUf[0] && !$past(cascMode)
     && !$past(wrEn && wrAddr == A_RST)) |-> cntLo == $past(cntLo) - 1'b1);
endmodule

// File: tb/tb_dual_down_timer.sv
module tb_dual_down_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, evtIn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [15:0] tickIn = '0;
  logic [7:0]  cntLo, cntHi;
  logic [1:0]  irqUf, irqCmp, pinOut;
  logic        ufOut;

  dual_down_timer dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tickIn(tickIn), .evtIn(evtIn), .cntLo(cntLo), .cntHi(cntHi),
    .irqUf(irqUf), .irqCmp(irqCmp), .ufOut(ufOut), .pinOut(pinOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChk = 0, nFail = 0, cyc = 0, ufSeen = 0;
  string curReq = "R1";
  bit done = 0;

  // behavioural reference state
  int mRld[2], mCmp[2], mCnt[2];
  bit [7:0] mCtl[2];
  bit mCasc, mEvt, s1, s2, s3;
  bit mWave[2], mUf[2], mMc[2];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit mPin(input int i);
    return mCtl[i][7] && (mWave[i] ^ mCtl[i][6]) && !(i == 0 && mCasc);
  endfunction

  task automatic modelStep();
    bit [1:0] rs, e, ufE, mE, wr;
    bit rise;
    int nCnt[2];
    int v;
    rs   = (wrEn && wrAddr == 3'd7) ? wrData[1:0] : 2'b00;
    rise = s2 && !s3;
    e[0] = mCtl[0][4] && (mEvt ? rise : tickIn[mCtl[0][3:0]]);
    e[1] = mCtl[1][4] && tickIn[mCtl[1][3:0]];
    ufE = 0; mE = 0; nCnt = mCnt;
    if (mCasc) begin
      v = mCnt[1] * 256 + mCnt[0];
      if (e[0]) begin
        if (mCtl[1][5] && v == mCmp[1] * 256 + mCmp[0]) mE[1] = 1;
        if (v == 0) begin nCnt = mRld; ufE[1] = 1; end
        else begin v--; nCnt[1] = v / 256; nCnt[0] = v % 256; end
      end
      if (rs != 0) nCnt = mRld;
      wr = {rs != 0, rs[0]};
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (e[i]) begin
          if (mCtl[i][5] && mCnt[i] == mCmp[i]) mE[i] = 1;
          if (mCnt[i] == 0) begin nCnt[i] = mRld[i]; ufE[i] = 1; end
          else nCnt[i] = mCnt[i] - 1;
        end
        if (rs[i]) nCnt[i] = mRld[i];
      end
      wr = rs;
    end
    for (int i = 0; i < 2; i++) begin
      if (wr[i]) mWave[i] = 0;
      else if (ufE[i]) mWave[i] = mCtl[i][5] ? 1'b0 : !mWave[i];
      else if (mE[i]) mWave[i] = 1;
      mUf[i] = ufE[i];
      mMc[i] = mE[i];
    end
    mCnt = nCnt;
    if (wrEn) begin
      case (wrAddr)
        3'd0: mRld[0] = wrData;
        3'd1: mRld[1] = wrData;
        3'd2: mCmp[0] = wrData;
        3'd3: mCmp[1] = wrData;
        3'd4: mCtl[0] = wrData;
        3'd5: mCtl[1] = wrData;
        3'd6: begin mCasc = wrData[0]; mEvt = wrData[1]; end
        default: ;
      endcase
    end
    s3 = s2; s2 = s1; s1 = evtIn;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mRld = '{0, 0}; mCmp = '{0, 0}; mCnt = '{0, 0}; mCtl = '{0, 0};
      mCasc = 0; mEvt = 0; s1 = 0; s2 = 0; s3 = 0;
      mWave = '{0, 0}; mUf = '{0, 0}; mMc = '{0, 0};
    end else modelStep();
  end

  // every-cycle comparison, on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rstN && !done) begin
      chk(cntLo == mCnt[0], curReq, "cntLo", cntLo, mCnt[0]);
      chk(cntHi == mCnt[1], curReq, "cntHi", cntHi, mCnt[1]);
      chk(irqUf == {mUf[1], mUf[0]}, curReq, "irqUf", irqUf, {mUf[1], mUf[0]});
      chk(ufOut == mUf[1], curReq, "ufOut", ufOut, mUf[1]);
      chk(irqCmp == {mMc[1], mMc[0]}, curReq, "irqCmp", irqCmp, {mMc[1], mMc[0]});
      chk(pinOut == {mPin(1), mPin(0)}, curReq, "pinOut", pinOut, {mPin(1), mPin(0)});
      if (irqUf[0]) ufSeen++;
    end
    for (int k = 0; k < 16; k++) tickIn[k] = (cyc % (k + 1) == 0);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1; wrAddr = 3'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int hold;
    idle(3);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(cntLo == 0 && cntHi == 0, "R1", "counts", {cntHi, cntLo}, 0);
    chk(pinOut == 0 && irqUf == 0 && irqCmp == 0, "R1", "outputs", {pinOut, irqUf, irqCmp}, 0);

    // R4 address map, R6 reset strobe loads reload value
    curReq = "R6";
    wr(0, 5);
    wr(7, 1);
    chk(cntLo == 5, "R6", "cntLo after strobe", cntLo, 5);

    // R2 / R8 underflow, toggle output at full rate
    curReq = "R2";
    wr(4, 8'h90);            // run, outEn, clkSel 0
    idle(40);
    chk(ufSeen > 0, "R2", "underflows seen", ufSeen, 1);

    // R5 reload write deferred
    curReq = "R5";
    wr(0, 9);
    chk(cntLo <= 5, "R5", "count unaffected by reload write", cntLo, 5);
    idle(30);

    // R3 stop holds count
    curReq = "R3";
    wr(4, 8'h00);
    hold = cntLo;
    idle(10);
    chk(cntLo == hold, "R3", "stopped count", cntLo, hold);
    // R3 clock select on counter 1 (tick every 3 cycles)
    wr(1, 4);
    wr(5, 8'h92);
    idle(60);

    // R7 PWM with compare, then polarity (R9)
    curReq = "R7";
    wr(5, 8'h00);
    wr(0, 7);
    wr(2, 3);
    wr(7, 1);
    wr(4, 8'hB0);            // outEn, pwm, run
    idle(50);
    curReq = "R9";
    wr(4, 8'hF0);            // add polarity
    idle(30);
    wr(4, 8'h30);            // output disabled
    idle(3);
    chk(pinOut[0] == 0, "R9", "disabled pin", pinOut[0], 0);
    // R7 compare at zero: underflow wins
    curReq = "R7";
    wr(2, 0);
    wr(4, 8'hB0);
    idle(30);

    // R8 non-PWM with compare data present: no compare pulses
    curReq = "R8";
    wr(2, 2);
    wr(4, 8'h91);            // clkSel 1
    idle(40);

    // R10 event mode
    curReq = "R10";
    wr(0, 2);
    wr(7, 1);
    wr(6, 2);
    wr(4, 8'h10);
    for (int n = 0; n < 12; n++) begin
      evtIn = 1; idle(4);
      evtIn = 0; idle(4);
    end
    wr(4, 8'h00);
    wr(6, 0);

    // R11 / R12 cascade
    curReq = "R11";
    wr(0, 3);
    wr(1, 2);
    wr(2, 0);
    wr(3, 1);
    wr(5, 8'hA0);            // pwm and outEn of the high half
    wr(6, 1);
    wr(7, 2);
    wr(4, 8'h90);            // run on counter 0, clkSel 0, outEn
    idle(1100);
    curReq = "R12";
    chk(pinOut[0] == 0, "R12", "low pin in cascade", pinOut[0], 0);
    wr(7, 1);
    chk(cntLo == 3 && cntHi == 2, "R12", "both reloaded by low strobe", {cntHi, cntLo}, 16'h0203);
    idle(20);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule